// File: doc/BRIEF.md
# Active Video Position Meter

The block measures where the active-video window sits relative to the horizontal and vertical sync pulses of an incoming video stream. It takes three single-bit inputs: a positive-going horizontal sync, a positive-going vertical sync and an active-video level. All three are asynchronous to the system clock and pass through two-flop synchronizers with edge detection before any logic uses them.

Software writes a control word that selects the measurement type and launches a run. In horizontal mode the block counts system clock cycles on each line. It reports the shortest gap from the end of horizontal sync to the start of video (first interval) and the shortest gap from the end of video to the next horizontal sync (second interval). In vertical mode it counts horizontal sync pulses to give the same two gaps in lines, measured against vertical sync. Each result is the minimum over a window bounded by vertical sync edges. Results saturate at 11 bits. The run bit clears itself when the window closes, and the results are then read back.

Top module: `av_window_meter`

## Requirements
- R1: A write to address 0 takes bit 1 as the mode (1 = horizontal, 0 = vertical) and bit 0 as the run bit. While a run is active, writes to address 0 are ignored: neither the mode nor the run bit changes.
- R2: Writing 1 to bit 0 of address 0 starts a run. Bit 0 reads back as 1 until the hardware clears it at the end of the window. Reading address 0 returns {mode, run} in bits 1:0.
- R3: In horizontal mode the window opens at the first vertical sync rising edge after the start and closes at the next vertical sync rising edge. The result at address 1 is the smallest number of clock cycles from a horizontal sync falling edge to the following active-video rising edge within the window.
- R4: In horizontal mode the result at address 2 is the smallest number of clock cycles from an active-video falling edge to the next horizontal sync rising edge within the window.
- R5: In vertical mode the window spans two whole frames between three vertical sync rising edges. Address 3 holds the smallest count of horizontal sync rising edges from a vertical sync falling edge up to the next active-video rising edge. Address 4 holds the smallest count of horizontal sync rising edges from the last active-video falling edge to the vertical sync rising edge.
- R6: If an interval count exceeds 2047, or if no interval is completed in the window (for example, active video never goes high), the result is 7FFh.
- R7: If active video is already high when the sync falling edge arrives, that first interval is taken as 1.
- R8: If active video is still high when the sync rising edge arrives, that second interval is taken as 0.
- R9: The minimum trackers restart from 7FFh on each start. Results at addresses 1 to 4 change only when a window closes: horizontal runs update addresses 1 and 2, vertical runs update addresses 3 and 4. After reset they read 7FFh, address 0 reads 0 and unmapped addresses read 0.
- R10: Read data is registered and reflects the address presented one clock earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address for reads and writes |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Registered read data |
| hsync_in | input | 1 | Horizontal sync, active high, asynchronous |
| vsync_in | input | 1 | Vertical sync, active high, asynchronous |
| av_in | input | 1 | Active-video level, asynchronous |

## Verification
Read data is due one clock after the address, so the bench presents the address on a falling edge and samples on the following falling edge. Each interval is the difference of two edges that pass through the same synchronizer depth, so the expected counts in clock cycles or lines follow directly from when the bench drives the edges. The window closes about three cycles after the bench raises vertical sync. The checks therefore poll the run bit until it reads 0 and only then compare results. Reads taken mid-run confirm that the previous results and the control word are still held.

// File: rtl/avwm_pkg.sv
package avwm_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_ARM  = 2'd1,
    SQ_RUN  = 2'd2
  } sq_state_e;

  localparam int ADR_CTRL = 0;
  localparam int ADR_H1   = 1;
  localparam int ADR_H2   = 2;
  localparam int ADR_V1   = 3;
  localparam int ADR_V2   = 4;
endpackage

// File: rtl/avwm_edge_sync.sv
module avwm_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic level,
  output logic rise,
  output logic fall
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-1:0], d};
  end

  assign level = chain[STAGES-1];
  assign rise  = chain[STAGES-1] & ~chain[STAGES];
  assign fall  = ~chain[STAGES-1] & chain[STAGES];
endmodule

// File: rtl/avwm_gap_track.sv
module avwm_gap_track #(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             en,
  input  logic             tick,
  input  logic             sync_rise,
  input  logic             sync_fall,
  input  logic             av_lvl,
  input  logic             av_rise,
  input  logic             av_fall,
  output logic [CNT_W-1:0] min1_now,
  output logic [CNT_W-1:0] min2_now
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  function automatic logic [CNT_W-1:0] sat_add(input logic [CNT_W-1:0] v, input logic t);
    return (t && (v != CNT_MAX)) ? v + CNT_W'(1) : v;
  endfunction

  logic             run1, run2;
  logic [CNT_W-1:0] cnt1, cnt2, min1, min2;
  logic [CNT_W-1:0] inc1, inc2, cap1_val, cap2_val;
  logic             cap1_v, cap2_v;

  always_comb begin
    inc1     = sat_add(cnt1, tick);
    inc2     = sat_add(cnt2, tick);
    cap1_v   = 1'b0;
    cap1_val = inc1;
    if (sync_fall && av_lvl) begin
      cap1_v   = 1'b1;
      cap1_val = CNT_W'(1);
    end else if (run1 && av_rise) begin
      cap1_v   = 1'b1;
    end
    cap2_v   = 1'b0;
    cap2_val = inc2;
    if (sync_rise && (av_lvl || av_fall)) begin
      cap2_v   = 1'b1;
      cap2_val = '0;
    end else if (run2 && sync_rise) begin
      cap2_v   = 1'b1;
    end
  end

  assign min1_now = (en && cap1_v && (cap1_val < min1)) ? cap1_val : min1;
  assign min2_now = (en && cap2_v && (cap2_val < min2)) ? cap2_val : min2;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      run1 <= 1'b0;
      run2 <= 1'b0;
      cnt1 <= '0;
      cnt2 <= '0;
      min1 <= CNT_MAX;
      min2 <= CNT_MAX;
    end else begin
      if (sync_fall) begin
        run1 <= ~av_lvl;
        cnt1 <= '0;
      end else if (run1) begin
        if (av_rise) run1 <= 1'b0;
        else         cnt1 <= inc1;
      end
      if (av_fall) begin
        run2 <= ~sync_rise;
        cnt2 <= '0;
      end else if (run2) begin
        if (sync_rise) run2 <= 1'b0;
        else           cnt2 <= inc2;
      end
      min1 <= min1_now;
      min2 <= min2_now;
    end
  end

  AST_TRACK_REFILL: assert property (@(posedge clk) disable iff (rst)
    clr |=> (min1 == CNT_MAX && min2 == CNT_MAX)); // R9

  AST_MIN_NEVER_GROWS: assert property (@(posedge clk) disable iff (rst)
    !clr |=> (min1 <= $past(min1) && min2 <= $past(min2))); // R3
endmodule

// File: rtl/avwm_seq.sv
module avwm_seq
  import avwm_pkg::*;
#(
  parameter int H_FRAMES = 1,
  parameter int V_FRAMES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ctrl_we,
  input  logic [1:0] ctrl_wdata,
  input  logic       vs_rise,
  output logic       start,
  output logic       mode,
  output logic       clr,
  output logic       en,
  output logic       done
);
  localparam int FRAME_W = $clog2(H_FRAMES + V_FRAMES + 1);

  sq_state_e          state;
  logic [FRAME_W-1:0] frames, need;
  logic               last;

  assign need  = mode ? FRAME_W'(H_FRAMES) : FRAME_W'(V_FRAMES);
  assign last  = (frames + FRAME_W'(1)) == need;
  assign start = (state != SQ_IDLE);
  assign en    = (state == SQ_RUN);
  assign clr   = (state == SQ_IDLE) && ctrl_we && ctrl_wdata[0];
  assign done  = en && vs_rise && last;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= SQ_IDLE;
      mode   <= 1'b0;
      frames <= '0;
    end else begin
      case (state)
        SQ_IDLE: if (ctrl_we) begin
          mode <= ctrl_wdata[1];
          if (ctrl_wdata[0]) state <= SQ_ARM;
        end
        SQ_ARM: if (vs_rise) begin
          state  <= SQ_RUN;
          frames <= '0;
        end
        SQ_RUN: if (vs_rise) begin
          if (last) state  <= SQ_IDLE;
          else      frames <= frames + FRAME_W'(1);
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  AST_RUN_HW_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $fell(start) |-> $past(done)); // R2

  AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (rst)
    start |=> $stable(mode)); // R1
endmodule

// File: rtl/av_window_meter.sv
module av_window_meter
  import avwm_pkg::*;
#(
  parameter int CNT_W    = 11,
  parameter int DATA_W   = 16,
  parameter int ADDR_W   = 3,
  parameter int SYNC_STG = 2,
  parameter int H_FRAMES = 1,
  parameter int V_FRAMES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              hsync_in,
  input  logic              vsync_in,
  input  logic              av_in
);
  localparam int               N_IN    = 3;
  localparam logic [CNT_W-1:0] RES_MAX = '1;

  logic [N_IN-1:0] raw, lvl, rse, fll;
  assign raw = {av_in, vsync_in, hsync_in};

  for (genvar g = 0; g < N_IN; g++) begin : g_sync
    avwm_edge_sync #(.STAGES(SYNC_STG)) sync_i (
      .clk(clk), .rst(rst), .d(raw[g]),
      .level(lvl[g]), .rise(rse[g]), .fall(fll[g])
    );
  end

  logic start, mode, clr, en, done, ctrl_we;
  assign ctrl_we = reg_we && (int'(reg_addr) == ADR_CTRL);

  avwm_seq #(.H_FRAMES(H_FRAMES), .V_FRAMES(V_FRAMES)) seq_i (
    .clk(clk), .rst(rst), .ctrl_we(ctrl_we), .ctrl_wdata(reg_wdata[1:0]),
    .vs_rise(rse[1]), .start(start), .mode(mode), .clr(clr), .en(en), .done(done)
  );

  logic [CNT_W-1:0] m1, m2;

  avwm_gap_track #(.CNT_W(CNT_W)) track_i (
    .clk(clk), .rst(rst), .clr(clr), .en(en),
    .tick(mode ? 1'b1 : rse[0]),
    .sync_rise(mode ? rse[0] : rse[1]),
    .sync_fall(mode ? fll[0] : fll[1]),
    .av_lvl(lvl[2]), .av_rise(rse[2]), .av_fall(fll[2]),
    .min1_now(m1), .min2_now(m2)
  );

  logic [CNT_W-1:0] h1_q, h2_q, v1_q, v2_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      h1_q <= RES_MAX;
      h2_q <= RES_MAX;
      v1_q <= RES_MAX;
      v2_q <= RES_MAX;
    end else if (done) begin
      if (mode) begin
        h1_q <= m1;
        h2_q <= m2;
      end else begin
        v1_q <= m1;
        v2_q <= m2;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      case (int'(reg_addr))
        ADR_CTRL: reg_rdata <= DATA_W'({mode, start});
        ADR_H1:   reg_rdata <= DATA_W'(h1_q);
        ADR_H2:   reg_rdata <= DATA_W'(h2_q);
        ADR_V1:   reg_rdata <= DATA_W'(v1_q);
        ADR_V2:   reg_rdata <= DATA_W'(v2_q);
        default:  reg_rdata <= '0;
      endcase
    end
  end

  AST_RESULTS_HELD: assert property (@(posedge clk) disable iff (rst)
    !done |=> $stable({h1_q, h2_q, v1_q, v2_q})); // R9

  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (int'(reg_addr) == ADR_H1) |=> (reg_rdata == DATA_W'($past(h1_q)))); // R10
endmodule

// File: tb/av_window_meter_tb_top.sv
module av_window_meter_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        hs = 1'b0, vs = 1'b0, av = 1'b0;
  int          n_chk = 0, n_bad = 0;
  bit          finished = 1'b0;

  always #4 clk = ~clk;

  av_window_meter dut_i (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .hsync_in(hs), .vsync_in(vs), .av_in(av)
  );

  // rows: t1/t2 of three lines, then expected first and second interval minimums
  localparam int HTAB [0:3][0:7] = '{
    '{ 7,  9,  5, 12,  8,  6,  5,  6},
    '{20,  3, 15,  4, 30, 10, 15,  3},
    '{ 2,  2, 40, 50,  3,  7,  2,  2},
    '{60, 70, 45, 80, 50, 65, 45, 65}
  };

  task automatic check(input string req, input int got, input int exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic drv(input logic h, input logic v, input logic a, input int n);
    hs = h; vs = v; av = a;
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int a, input int d);
    reg_we = 1'b1; reg_addr = 3'(a); reg_wdata = 16'(d);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    reg_addr = 3'(a);
    @(negedge clk);
    v = int'(reg_rdata);
  endtask

  task automatic hline(input int t1, input int t2);
    drv(1, 0, 0, 3); drv(0, 0, 0, t1); drv(0, 0, 1, 4); drv(0, 0, 0, t2);
  endtask

  task automatic vpulse();
    drv(0, 1, 0, 3); drv(0, 0, 0, 3);
  endtask

  task automatic tail();
    drv(1, 0, 0, 3); drv(0, 0, 0, 2); vpulse();
  endtask

  task automatic vframe(input int vb, input int va, input int vf);
    for (int i = 0; i < vb; i++) begin drv(1, 0, 0, 2); drv(0, 0, 0, 7); end
    for (int i = 0; i < va; i++) begin
      drv(1, 0, 0, 2); drv(0, 0, 0, 2); drv(0, 0, 1, 3); drv(0, 0, 0, 2);
    end
    for (int i = 0; i < vf; i++) begin drv(1, 0, 0, 2); drv(0, 0, 0, 7); end
  endtask

  task automatic wait_idle(input string req);
    int v = 1;
    for (int i = 0; i < 400 && (v & 1) != 0; i++) rd(0, v);
    check(req, v & 1, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    int v;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // reset state (R9)
    rd(0, v); check("R9 reset ctrl", v, 0);
    for (int a = 1; a <= 4; a++) begin rd(a, v); check("R9 reset result", v, 'h7FF); end
    rd(5, v); check("R9 unmapped", v, 0);

    // horizontal table (R3 R4 R9)
    for (int r = 0; r < 4; r++) begin
      wr(0, 3);
      rd(0, v); check("R2 run bit set", v, 3);
      vpulse();
      for (int l = 0; l < 3; l++) hline(HTAB[r][2*l], HTAB[r][2*l+1]);
      tail();
      wait_idle("R2 hw clear");
      rd(1, v); check("R3 H1 min", v, HTAB[r][6]);
      rd(2, v); check("R4 H2 min", v, HTAB[r][7]);
    end

    // vertical two-frame run (R5), horizontal results untouched (R1)
    wr(0, 1);
    vpulse(); vframe(3, 4, 5);
    vpulse(); vframe(2, 3, 6);
    vpulse();
    wait_idle("R5 hw clear");
    rd(3, v); check("R5 V1 min", v, 3);
    rd(4, v); check("R5 V2 min", v, 5);
    rd(1, v); check("R1 vertical leaves H1", v, 45);
    rd(0, v); check("R1 mode reads vertical", v, 0);

    // writes during a run ignored, results held mid-run (R1 R9 R10)
    wr(0, 3);
    vpulse();
    hline(6, 7);
    wr(0, 0);
    rd(0, v); check("R1 busy write ignored", v, 3);
    rd(1, v); check("R9 H1 held mid-run", v, 45);
    hline(9, 9);
    tail();
    wait_idle("R2 hw clear busy");
    rd(1, v); check("R1 H1 after busy write", v, 6);
    rd(2, v); check("R4 H2 stretched gap", v, 9);
    rd(3, v); check("R1 V1 untouched", v, 3);

    // AV already high at hsync fall (R7)
    wr(0, 3);
    vpulse();
    hline(10, 8);
    drv(1, 0, 0, 2); drv(1, 0, 1, 2); drv(0, 0, 1, 3); drv(0, 0, 0, 9);
    hline(12, 11);
    tail();
    wait_idle("R2 hw clear r7");
    rd(1, v); check("R7 forced one", v, 1);
    rd(2, v); check("R4 H2 with forced T1", v, 8);

    // AV still high at hsync rise (R8)
    wr(0, 3);
    vpulse();
    hline(10, 6);
    drv(0, 0, 1, 2); drv(1, 0, 1, 3); drv(0, 0, 1, 2); drv(0, 0, 0, 7);
    hline(9, 9);
    tail();
    wait_idle("R2 hw clear r8");
    rd(2, v); check("R8 zero gap", v, 0);
    rd(1, v); check("R7 forced one again", v, 1);

    // no active video at all (R6)
    wr(0, 3);
    vpulse();
    for (int l = 0; l < 3; l++) begin drv(1, 0, 0, 3); drv(0, 0, 0, 10); end
    tail();
    wait_idle("R2 hw clear r6a");
    rd(1, v); check("R6 no video H1", v, 'h7FF);
    rd(2, v); check("R6 no video H2", v, 'h7FF);

    // counter overflow (R6)
    wr(0, 3);
    vpulse();
    hline(2100, 5);
    tail();
    wait_idle("R2 hw clear r6b");
    rd(1, v); check("R6 overflow H1", v, 'h7FF);
    rd(2, v); check("R4 H2 beside overflow", v, 5);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule